// File: doc/BRIEF.md
# Accumulator Processor with Selectable Operand Addressing

This block is a small multicycle processor built around one accumulator and one index register. It fetches 16-bit instructions from a synchronous single-port memory that sits outside the block. It then walks a fixed sequence of states: it forms the effective address, reads any operand it needs, and executes. Every instruction picks one of five ways to reach its operand: the field is the address, the field is the value, the field points at a word that holds the address, the field is offset by the index register, or the field is offset by the program counter.

The sequencer has these states. FETCH copies the PC into the memory address register. IWAIT covers the one-cycle read latency. ILOAD latches the instruction word. ADDR forms the effective address. PWAIT and PLOAD read the pointer word for indirect mode. OWAIT and OLOAD read the data operand. EXEC performs the operation and advances the PC. HALT is terminal.

The transitions are as follows. FETCH goes to IWAIT, then ILOAD, then ADDR. ADDR goes to EXEC for instructions with no address, and for loads in value mode. It goes to PWAIT for indirect mode. For other operand reads it goes to OWAIT. For stores and branches it goes to EXEC. PLOAD goes to OWAIT when a data operand is still needed, otherwise to EXEC. OLOAD goes to EXEC. EXEC returns to FETCH, or goes to HALT for the stop instruction.

Top module: `acc_mode_cpu`

## Requirements
- R1: After reset the first instruction comes from address 0. An instruction word holds the opcode in bits 15:12, the mode in bits 11:9 and a 9-bit field in bits 8:0. The opcodes are 0 stop, 1 load, 2 store, 3 add, 4 subtract, 5 load-index, 6 decrement-index, 7 branch-if-accumulator-nonnegative, 8 branch-if-index-nonnegative and 9 output. Opcodes 10 to 15 do nothing.
- R2: In mode 0 (direct), the field is the operand address. A store writes the accumulator to that address.
- R3: In mode 1 (value), the operand is the field sign-extended to 16 bits, and no data read is made.
- R4: In mode 2 (indirect), bits 8:0 of the word at the field address form the operand address. This costs one extra memory read.
- R5: In mode 3 (indexed), the address is the field plus the index register, taken modulo 512.
- R6: In mode 4 (relative), the address is the field plus the address of the instruction itself, taken modulo 512. The field may be negative.
- R7: Add and subtract wrap modulo 2^16. Load-index sets the index register from the operand. Decrement-index lowers it by one.
- R8: Branches go to the effective address. The accumulator branch is taken when accumulator bit 15 is 0. The index branch is taken when index bit 15 is 0, so a counting loop ends when the index steps from 0 to -1.
- R9: The output instruction raises out_valid for exactly one cycle, with out_data equal to the accumulator.
- R10: The stop instruction raises halted. After that the block makes no writes and no outputs, and the PC stays fixed.
- R11: During reset, halted, out_valid and mem_we are low and mem_addr is 0.
- R12: A value-mode instruction, or one without an address, takes 5 cycles. Direct, indexed and relative operand reads take 7 cycles. Indirect operand reads take 9 cycles. Advancing the PC adds no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 9 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data (accumulator) |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |
| out_valid | output | 1 | Output strobe |
| out_data | output | 16 | Output value |
| halted | output | 1 | Processor stopped |

## Verification
A wrong state transition changes the cycle count of an instruction. It therefore shows up at the ports as a shifted distance between output strobes, which differs by two cycles for each missing or extra read. A wrong address path, a wrong latch from the read data or a wrong branch condition corrupts the value on out_data at the very next output instruction. A running loop sum magnifies an off-by-one in the index handling into a visibly wrong total. Stray stores show up in the external memory contents as soon as the program halts.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    typedef enum logic [3:0] {
        OP_HALT = 4'd0,
        OP_LDA  = 4'd1,
        OP_STA  = 4'd2,
        OP_ADD  = 4'd3,
        OP_SUB  = 4'd4,
        OP_LDX  = 4'd5,
        OP_DECX = 4'd6,
        OP_BRP  = 4'd7,
        OP_BRPX = 4'd8,
        OP_OUT  = 4'd9
    } opcode_e;

    typedef enum logic [2:0] {
        MD_DIR = 3'd0,
        MD_IMM = 3'd1,
        MD_IND = 3'd2,
        MD_IDX = 3'd3,
        MD_REL = 3'd4
    } amode_e;

    typedef enum logic [3:0] {
        S_FETCH, S_IWAIT, S_ILOAD, S_ADDR,
        S_PWAIT, S_PLOAD, S_OWAIT, S_OLOAD,
        S_EXEC,  S_HALT
    } cpu_state_e;

    function automatic logic needs_addr(input logic [3:0] op);
        return op inside {OP_LDA, OP_STA, OP_ADD, OP_SUB, OP_LDX, OP_BRP, OP_BRPX};
    endfunction

    function automatic logic reads_opnd(input logic [3:0] op);
        return op inside {OP_LDA, OP_ADD, OP_SUB, OP_LDX};
    endfunction

endpackage

// File: rtl/acc_ea_gen.sv
module acc_ea_gen #(
    parameter int ADDR_W = 9,
    parameter int MODE_W = 3
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [ADDR_W-1:0] field,
    input  logic [ADDR_W-1:0] x_low,
    input  logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] ea
);
    import acc_cpu_pkg::*;

    always_comb begin
        case (mode)
            MD_IDX:  ea = field + x_low;
            MD_REL:  ea = field + pc;
            default: ea = field;
        endcase
    end
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit #(
    parameter int DATA_W = 16
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] acc_nx,
    output logic [DATA_W-1:0] x_nx,
    output logic              acc_we,
    output logic              x_we,
    output logic              take_br,
    output logic              do_store,
    output logic              do_out,
    output logic              do_halt
);
    import acc_cpu_pkg::*;

    always_comb begin
        acc_nx   = acc;
        x_nx     = x;
        acc_we   = 1'b0;
        x_we     = 1'b0;
        take_br  = 1'b0;
        do_store = 1'b0;
        do_out   = 1'b0;
        do_halt  = 1'b0;
        case (op)
            OP_LDA:  begin acc_nx = opnd;       acc_we = 1'b1; end
            OP_ADD:  begin acc_nx = acc + opnd; acc_we = 1'b1; end
            OP_SUB:  begin acc_nx = acc - opnd; acc_we = 1'b1; end
            OP_LDX:  begin x_nx = opnd;         x_we = 1'b1;   end
            OP_DECX: begin x_nx = x - 1'b1;     x_we = 1'b1;   end
            OP_STA:  do_store = 1'b1;
            OP_BRP:  take_br = ~acc[DATA_W-1];
            OP_BRPX: take_br = ~x[DATA_W-1];
            OP_OUT:  do_out = 1'b1;
            OP_HALT: do_halt = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_mode_cpu.sv
module acc_mode_cpu #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              halted
);
    import acc_cpu_pkg::*;

    localparam int OP_W   = 4;
    localparam int MODE_W = 3;
    localparam int OP_LSB = DATA_W - OP_W;
    localparam int SEXT_W = DATA_W - ADDR_W;

    cpu_state_e state_q, state_d;
    logic [ADDR_W-1:0] pc, mar, ea;
    logic [DATA_W-1:0] mdr, ir, acc, x, opnd;
    logic [3:0]        op;
    logic [MODE_W-1:0] mode;
    logic [ADDR_W-1:0] field;
    logic [DATA_W-1:0] acc_nx, x_nx;
    logic acc_we, x_we, take_br, do_store, do_out, do_halt;

    assign op    = ir[OP_LSB +: OP_W];
    assign mode  = ir[ADDR_W +: MODE_W];
    assign field = ir[ADDR_W-1:0];
    assign opnd  = (mode == MD_IMM) ? {{SEXT_W{field[ADDR_W-1]}}, field} : mdr;

    acc_ea_gen #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_ea (
        .mode(mode), .field(field), .x_low(x[ADDR_W-1:0]), .pc(pc), .ea(ea)
    );

    acc_exec_unit #(.DATA_W(DATA_W)) u_exec (
        .op(op), .acc(acc), .x(x), .opnd(opnd),
        .acc_nx(acc_nx), .x_nx(x_nx), .acc_we(acc_we), .x_we(x_we),
        .take_br(take_br), .do_store(do_store), .do_out(do_out), .do_halt(do_halt)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_FETCH;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FETCH: state_d = S_IWAIT;
            S_IWAIT: state_d = S_ILOAD;
            S_ILOAD: state_d = S_ADDR;
            S_ADDR: begin
                if (!needs_addr(op))                         state_d = S_EXEC;
                else if (mode == MD_IND)                     state_d = S_PWAIT;
                else if (reads_opnd(op) && mode != MD_IMM)   state_d = S_OWAIT;
                else                                         state_d = S_EXEC;
            end
            S_PWAIT: state_d = S_PLOAD;
            S_PLOAD: state_d = reads_opnd(op) ? S_OWAIT : S_EXEC;
            S_OWAIT: state_d = S_OLOAD;
            S_OLOAD: state_d = S_EXEC;
            S_EXEC:  state_d = do_halt ? S_HALT : S_FETCH;
            S_HALT:  state_d = S_HALT;
            default: state_d = S_FETCH;
        endcase
    end

    // datapath registers and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0; mar <= '0; mdr <= '0; ir <= '0;
            acc <= '0; x <= '0;
            out_valid <= 1'b0; out_data <= '0; halted <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            unique case (state_q)
                S_FETCH: mar <= pc;
                S_ILOAD: begin ir <= mem_rdata; mdr <= mem_rdata; end
                S_ADDR:  mar <= ea;
                S_PLOAD: begin mar <= mem_rdata[ADDR_W-1:0]; mdr <= mem_rdata; end
                S_OLOAD: mdr <= mem_rdata;
                S_EXEC: begin
                    if (acc_we) acc <= acc_nx;
                    if (x_we)   x   <= x_nx;
                    if (do_halt)      halted <= 1'b1;
                    else if (take_br) pc <= mar;
                    else              pc <= pc + 1'b1;
                    if (do_out) begin
                        out_valid <= 1'b1;
                        out_data  <= acc;
                    end
                end
                default: ;
            endcase
        end
    end

    // memory side
    assign mem_addr  = mar;
    assign mem_we    = (state_q == S_EXEC) && do_store;
    assign mem_wdata = acc;

    // R1
    fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IWAIT) |-> (mem_addr == pc));
    // R3
    imm_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADDR && mode == MD_IMM) |=> (state_q == S_EXEC));
    // R4
    ind_extra_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADDR && mode == MD_IND && needs_addr(op)) |=> (state_q == S_PWAIT));
    // R9
    out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc) && !mem_we && !out_valid));
    // R12
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EXEC && !do_halt && !take_br) |=> (pc == ADDR_W'($past(pc) + 1'b1)));
    // R2
    store_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
endmodule

// File: tb/acc_mode_cpu_bench.sv
`timescale 1ns/1ps
module acc_mode_cpu_bench;
    localparam logic [3:0] HALT = 0, LDA = 1, STA = 2, ADD = 3, SUB = 4, LDX = 5,
                           DECX = 6, BRP = 7, BRPX = 8, OUTI = 9, NOPI = 12;
    localparam logic [2:0] DIR = 0, IMM = 1, IND = 2, IDX = 3, REL = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [8:0]  mem_addr;
    logic        mem_we, out_valid, halted;
    logic [15:0] mem_wdata, mem_rdata, out_data;
    logic [15:0] mem [512];

    int checks = 0, errors = 0, cyc = 0, n_out = 0, after_halt = 0;
    logic [15:0] outs [64];
    int          out_cyc [64];

    always #2.5 clk = ~clk;

    acc_mode_cpu u_acc_mode_cpu (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .out_valid(out_valid),
        .out_data(out_data), .halted(halted)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
        cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (rst_n && out_valid && n_out < 64) begin
            outs[n_out] = out_data; out_cyc[n_out] = cyc; n_out++;
        end
        if (rst_n && halted && (mem_we || out_valid)) after_halt++;
    end

    function automatic logic [15:0] enc(input logic [3:0] op, input logic [2:0] md, input int f);
        logic [8:0] f9 = f[8:0];
        return {op, md, f9};
    endfunction

    function automatic logic [15:0] sext9(input int f);
        logic [8:0] f9 = f[8:0];
        return {{7{f9[8]}}, f9};
    endfunction

    function automatic logic [15:0] ref_alu(input logic [15:0] a, input logic [15:0] b, input bit sub);
        return sub ? a - b : a + b;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr_mem();
        for (int i = 0; i < 512; i++) mem[i] = 16'h0;
    endtask

    task automatic run_prog(input int max_cyc);
        int k = 0;
        rst_n = 1'b0; n_out = 0; after_halt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        while (!halted && k < max_cyc) begin @(negedge clk); k++; end
        chk(halted, "R10 halt reached", {31'd0, halted}, 1);
    endtask

    initial begin
        void'($urandom(32'd5171));
        clr_mem();
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!halted && !out_valid && !mem_we && mem_addr == 0, "R11 reset state",
            {mem_addr, 1'b0, halted, out_valid, mem_we}, 0);

        // R1: start at 0, no-op opcode does nothing
        clr_mem();
        mem[0] = enc(LDA, IMM, 9); mem[1] = enc(NOPI, DIR, 40);
        mem[2] = enc(OUTI, DIR, 0); mem[3] = enc(HALT, DIR, 0);
        run_prog(200);
        chk(n_out == 1 && outs[0] == 16'd9, "R1 fetch/no-op", outs[0], 9);

        // R5 R6 R8: indexed totalizer loop, relative backward branch
        begin
            logic [15:0] sum = 0;
            clr_mem();
            mem[0] = enc(LDA, IMM, 0); mem[1] = enc(LDX, IMM, 19);
            mem[2] = enc(ADD, IDX, 60); mem[3] = enc(DECX, DIR, 0);
            mem[4] = enc(BRPX, REL, -2); mem[5] = enc(OUTI, DIR, 0);
            mem[6] = enc(HALT, DIR, 0);
            for (int i = 60; i < 80; i++) begin
                mem[i] = 16'($urandom_range(0, 999)); sum += mem[i];
            end
            run_prog(3000);
            chk(n_out == 1 && outs[0] == sum, "R5 R8 totalizer", outs[0], sum);
        end

        // R5 index wrap
        clr_mem();
        mem[0] = enc(LDX, IMM, 30); mem[1] = enc(LDA, IDX, 500);
        mem[2] = enc(OUTI, DIR, 0); mem[3] = enc(HALT, DIR, 0); mem[18] = 16'h5A5A;
        run_prog(200);
        chk(n_out == 1 && outs[0] == 16'h5A5A, "R5 index wrap", outs[0], 16'h5A5A);

        // R7 wrap and R2 store
        clr_mem();
        mem[0] = enc(LDA, DIR, 20); mem[1] = enc(ADD, IMM, 1); mem[2] = enc(OUTI, DIR, 0);
        mem[3] = enc(STA, DIR, 21); mem[4] = enc(HALT, DIR, 0); mem[20] = 16'h7FFF;
        run_prog(200);
        chk(n_out == 1 && outs[0] == 16'h8000, "R7 add wrap", outs[0], 16'h8000);
        chk(mem[21] == 16'h8000, "R2 store", mem[21], 16'h8000);

        // R8 accumulator branch at -1, 0, 5
        for (int t = 0; t < 3; t++) begin
            int v = (t == 0) ? -1 : (t == 1) ? 0 : 5;
            logic [15:0] e = (v >= 0) ? 16'd100 : sext9(v);
            clr_mem();
            mem[0] = enc(LDA, IMM, v); mem[1] = enc(BRP, DIR, 4); mem[2] = enc(OUTI, DIR, 0);
            mem[3] = enc(HALT, DIR, 0); mem[4] = enc(LDA, IMM, 100);
            mem[5] = enc(OUTI, DIR, 0); mem[6] = enc(HALT, DIR, 0);
            run_prog(200);
            chk(n_out == 1 && outs[0] == e, "R8 branch acc", outs[0], e);
        end

        // R12 R9 R4 timing between output strobes, then R10 hold
        clr_mem();
        mem[0] = enc(OUTI, DIR, 0); mem[1] = enc(LDA, IMM, 5); mem[2] = enc(OUTI, DIR, 0);
        mem[3] = enc(LDA, DIR, 100); mem[4] = enc(OUTI, DIR, 0); mem[5] = enc(LDA, IND, 101);
        mem[6] = enc(OUTI, DIR, 0); mem[7] = enc(HALT, DIR, 0);
        mem[100] = 16'h1234; mem[101] = 16'hFE00 | 16'd102; mem[102] = 16'h0BCD;
        run_prog(300);
        chk(n_out == 4, "R9 strobe count", n_out, 4);
        chk(outs[1] == 5 && outs[2] == 16'h1234 && outs[3] == 16'h0BCD, "R9 R4 values", outs[3], 16'h0BCD);
        chk(out_cyc[1] - out_cyc[0] == 10, "R12 value-mode gap", out_cyc[1] - out_cyc[0], 10);
        chk(out_cyc[2] - out_cyc[1] == 12, "R12 direct gap", out_cyc[2] - out_cyc[1], 12);
        chk(out_cyc[3] - out_cyc[2] == 14, "R12 indirect gap", out_cyc[3] - out_cyc[2], 14);
        repeat (20) @(negedge clk);
        chk(halted && n_out == 4 && after_halt == 0, "R10 frozen after stop", after_halt, 0);

        // random mode mix: R2 R3 R4 R5 R6 R7
        for (int it = 0; it < 40; it++) begin
            int md = $urandom_range(0, 4);
            int xv = $urandom_range(0, 50);
            int a0 = $urandom_range(0, 511) - 256;
            int f = 0, p = 0;
            bit sb = 1'($urandom_range(0, 1));
            logic [15:0] v = 16'($urandom);
            logic [15:0] opnd = v, e;
            string tag;
            clr_mem();
            case (md)
                0: begin f = $urandom_range(100, 200); mem[f] = v; tag = "R2 direct"; end
                1: begin f = $urandom_range(0, 511); opnd = sext9(f); tag = "R3 value"; end
                2: begin f = 300; p = $urandom_range(100, 200);
                         mem[300] = {7'($urandom), 9'(p)}; mem[p] = v; tag = "R4 indirect"; end
                3: begin f = $urandom_range(100, 200); mem[f + xv] = v; tag = "R5 indexed"; end
                default: begin f = $urandom_range(100, 200); mem[2 + f] = v; tag = "R6 relative"; end
            endcase
            mem[0] = enc(LDX, IMM, xv); mem[1] = enc(LDA, IMM, a0);
            mem[2] = enc(sb ? SUB : ADD, 3'(md), f);
            mem[3] = enc(OUTI, DIR, 0); mem[4] = enc(HALT, DIR, 0);
            e = ref_alu(sext9(a0), opnd, sb);
            run_prog(200);
            chk(n_out == 1 && outs[0] == e, tag, outs[0], e);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule